// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

This block drives the command pins of a synchronous DRAM array to carry out one burst read of four beats on a 64-bit data path. A requester raises a request with a bank, row and column address. The sequencer then opens the row and waits out a programmable row-to-column gap. It issues a read that asks the memory to close the row by itself, waits out the programmable CAS latency, captures four consecutive data beats and holds the command bus quiet through a programmable recovery window. When the four words are captured, it reports them with a single-cycle completion pulse.

The spacing, latency and recovery values are live configuration inputs. They must be held stable while an access is in progress. A request is taken only while the sequencer is idle. A request that is held high during an access waits for the next idle cycle. No other command is issued while an access is in progress.

Top module: `sdram_burst_rd_seq`

## Requirements
- R1: While idle, `rdy_o` is 1 and the command pins are in deselect (`sd_cs_n`=1, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1). A request present at a clock edge while `rdy_o` is 1 is accepted. The next cycle drives an activate (`sd_cs_n`=0, `sd_ras_n`=0, `sd_cas_n`=1, `sd_we_n`=1) with `sd_ba_o` = `addr_i[19]` and `sd_a_o` = the row, `addr_i[18:8]`.
- R2: The read command comes N cycles after the activate. `rcd_code_i` values 0, 1, 2 and 3 give N = 2, 3, 4 and 4.
- R3: Each of the N-1 cycles between the activate and the read drives a NOP (`sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=1, `sd_we_n`=1).
- R4: The read command is `sd_cs_n`=0, `sd_ras_n`=1, `sd_cas_n`=0, `sd_we_n`=1. It carries the latched bank, `sd_a_o[10]`=1 (auto-precharge), the column `addr_i[7:0]` on `sd_a_o[7:0]`, and zeros on `sd_a_o[9:8]`.
- R5: The first data beat is sampled L cycles after the read cycle. `cl_code_i` values 0, 1, 2 and 3 give L = 1, 1, 2 and 3. The L-1 cycles in between drive NOP.
- R6: Four consecutive beats are captured. Beat i lands on `rd_data_o[64*i +: 64]`. `sd_dq_i` is ignored in all other cycles.
- R7: `ack_o` is high for exactly one cycle, the cycle after the fourth beat. `rd_data_o` is valid in that cycle.
- R8: After the fourth beat, `tpc_code_i`+1 recovery cycles follow. Each drives a NOP and has `rdy_o`=0. `rdy_o` returns to 1 in the cycle after the last recovery cycle.
- R9: A request or address change while `rdy_o` is 0 has no effect. No activate or read is issued until the sequencer is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Read request |
| addr_i | input | 20 | {bank, row, column} |
| rcd_code_i | input | 2 | Activate-to-read spacing code |
| cl_code_i | input | 2 | CAS latency code |
| tpc_code_i | input | 3 | Recovery length code |
| rdy_o | output | 1 | Idle and able to accept a request |
| ack_o | output | 1 | Completion pulse |
| rd_data_o | output | 256 | Four captured beats, beat 0 lowest |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_ba_o | output | 1 | Bank select |
| sd_a_o | output | 11 | Multiplexed row/column address |
| sd_dq_i | input | 64 | Read data from memory |

## Verification
A state register that leaves a state too early or too late shows up on the command pins in the same cycle. The read lands one cycle off, or a NOP becomes a read or an activate. A wrong wait count also shifts the capture window, so a wrong beat shows up in `rd_data_o` by the completion cycle. A faulty recovery count moves the rising edge of `rdy_o`. Every cycle of every access is compared, so a fault is reported within the access in which it occurs.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCDW, ST_RD, ST_CLW, ST_DATA, ST_TPC
  } seq_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_DESEL = 4'b1111;
  localparam sd_cmd_t CMD_NOP   = 4'b0111;
  localparam sd_cmd_t CMD_ACT   = 4'b0011;
  localparam sd_cmd_t CMD_READ  = 4'b0101;

  // activate-to-read spacing in cycles: 2..4
  function automatic logic [2:0] rcd_cycles(input logic [1:0] code);
    return (code == 2'd3) ? 3'd4 : ({1'b0, code} + 3'd2);
  endfunction

  // CAS latency in cycles: 1..3
  function automatic logic [1:0] cas_cycles(input logic [1:0] code);
    return (code == 2'd0) ? 2'd1 : code;
  endfunction
endpackage

// File: rtl/sdr_rd_fsm.sv
module sdr_rd_fsm
  import sdr_rd_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int TPC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [1:0]       rcd_code_i,
  input  logic [1:0]       cl_code_i,
  input  logic [TPC_W-1:0] tpc_code_i,
  output seq_st_e          st_o,
  output logic             accept_o,
  output logic [BEATS-1:0] beat_en_o,
  output logic             ack_o
);
  localparam int BIX_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int CNT_W = (TPC_W > BIX_W) ? ((TPC_W > 2) ? TPC_W : 2)
                                         : ((BIX_W > 2) ? BIX_W : 2);
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ack_q, ack_d;
  logic [1:0]       lat;

  assign lat = cas_cycles(cl_code_i);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: if (req_i) begin
        st_d  = ST_ACT;
        cnt_d = '0;
      end
      ST_ACT: begin
        st_d  = ST_RCDW;
        cnt_d = CNT_W'(rcd_cycles(rcd_code_i) - 3'd2);
      end
      ST_RCDW: if (cnt_q == '0) st_d = ST_RD;
               else cnt_d = cnt_q - 1'b1;
      ST_RD: if (lat == 2'd1) begin
        st_d  = ST_DATA;
        cnt_d = '0;
      end else begin
        st_d  = ST_CLW;
        cnt_d = CNT_W'(lat - 2'd2);
      end
      ST_CLW: if (cnt_q == '0) begin
        st_d  = ST_DATA;
        cnt_d = '0;
      end else cnt_d = cnt_q - 1'b1;
      ST_DATA: if (cnt_q == LAST_BEAT) begin
        st_d  = ST_TPC;
        cnt_d = CNT_W'(tpc_code_i);
      end else cnt_d = cnt_q + 1'b1;
      ST_TPC: if (cnt_q == '0) st_d = ST_IDLE;
              else cnt_d = cnt_q - 1'b1;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ack_d = (st_q == ST_DATA) && (cnt_q == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ack_q <= ack_d;
    end
  end

  for (genvar i = 0; i < BEATS; i++) begin : g_beat_en
    assign beat_en_o[i] = (st_q == ST_DATA) && (cnt_q == CNT_W'(i));
  end

  assign st_o     = st_q;
  assign accept_o = (st_q == ST_IDLE) && req_i;
  assign ack_o    = ack_q;

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q);
  p_beat_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(beat_en_o));
  p_tpc_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TPC && cnt_q != '0) |=> (st_q == ST_TPC));
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |=> (st_q != ST_ACT));
endmodule

// File: rtl/sdr_rd_cmd.sv
module sdr_rd_cmd
  import sdr_rd_pkg::*;
#(
  parameter int BA_W   = 1,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  seq_st_e                      st_i,
  input  logic [BA_W+ROW_W+COL_W-1:0]  addr_q_i,
  output sd_cmd_t                      cmd_o,
  output logic [BA_W-1:0]              ba_o,
  output logic [ROW_W-1:0]             a_o
);
  localparam int RB = COL_W;
  localparam int BB = COL_W + ROW_W;

  logic [ROW_W-1:0] col_word;

  always_comb begin
    col_word         = '0;
    col_word[COL_W-1:0] = addr_q_i[COL_W-1:0];
    col_word[AP_BIT] = 1'b1;
  end

  always_comb begin
    cmd_o = CMD_NOP;
    ba_o  = addr_q_i[BB +: BA_W];
    a_o   = '0;
    case (st_i)
      ST_IDLE: cmd_o = CMD_DESEL;
      ST_ACT: begin
        cmd_o = CMD_ACT;
        a_o   = addr_q_i[RB +: ROW_W];
      end
      ST_RD: begin
        cmd_o = CMD_READ;
        a_o   = col_word;
      end
      default: cmd_o = CMD_NOP;
    endcase
  end

  p_read_ap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_o.cs_n && !cmd_o.cas_n) |-> (a_o[AP_BIT] && cmd_o.we_n));
  p_act_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_o.cs_n && !cmd_o.ras_n) |=> (cmd_o == CMD_NOP));
endmodule

// File: rtl/sdr_rd_capture.sv
module sdr_rd_capture #(
  parameter int BEATS = 4,
  parameter int DQ_W  = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BEATS-1:0]      beat_en_i,
  input  logic [DQ_W-1:0]       dq_i,
  output logic [BEATS*DQ_W-1:0] data_o
);
  for (genvar i = 0; i < BEATS; i++) begin : g_beat
    logic [DQ_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            word_q <= '0;
      else if (beat_en_i[i]) word_q <= dq_i;
    end
    assign data_o[i*DQ_W +: DQ_W] = word_q;
  end
endmodule

// File: rtl/sdram_burst_rd_seq.sv
module sdram_burst_rd_seq
  import sdr_rd_pkg::*;
#(
  parameter int BA_W   = 1,
  parameter int ROW_W  = 11,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 10,
  parameter int DQ_W   = 64,
  parameter int BEATS  = 4,
  parameter int TPC_W  = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_i,
  input  logic [BA_W+ROW_W+COL_W-1:0] addr_i,
  input  logic [1:0]                  rcd_code_i,
  input  logic [1:0]                  cl_code_i,
  input  logic [TPC_W-1:0]            tpc_code_i,
  output logic                        rdy_o,
  output logic                        ack_o,
  output logic [BEATS*DQ_W-1:0]       rd_data_o,
  output logic                        sd_cs_n_o,
  output logic                        sd_ras_n_o,
  output logic                        sd_cas_n_o,
  output logic                        sd_we_n_o,
  output logic [BA_W-1:0]             sd_ba_o,
  output logic [ROW_W-1:0]            sd_a_o,
  input  logic [DQ_W-1:0]             sd_dq_i
);
  localparam int AW = BA_W + ROW_W + COL_W;

  logic             rst_m_q, rst_s_q;
  seq_st_e          st;
  logic             accept;
  logic [BEATS-1:0] beat_en;
  logic [AW-1:0]    addr_q;
  sd_cmd_t          cmd;

  // reset released synchronously
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q)    addr_q <= '0;
    else if (accept) addr_q <= addr_i;
  end

  sdr_rd_fsm #(.BEATS(BEATS), .TPC_W(TPC_W)) u_fsm (
    .clk(clk), .rst_n(rst_s_q), .req_i(req_i),
    .rcd_code_i(rcd_code_i), .cl_code_i(cl_code_i), .tpc_code_i(tpc_code_i),
    .st_o(st), .accept_o(accept), .beat_en_o(beat_en), .ack_o(ack_o)
  );

  sdr_rd_cmd #(.BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT)) u_cmd (
    .clk(clk), .rst_n(rst_s_q), .st_i(st), .addr_q_i(addr_q),
    .cmd_o(cmd), .ba_o(sd_ba_o), .a_o(sd_a_o)
  );

  sdr_rd_capture #(.BEATS(BEATS), .DQ_W(DQ_W)) u_cap (
    .clk(clk), .rst_n(rst_s_q), .beat_en_i(beat_en),
    .dq_i(sd_dq_i), .data_o(rd_data_o)
  );

  assign rdy_o      = (st == ST_IDLE);
  assign sd_cs_n_o  = cmd.cs_n;
  assign sd_ras_n_o = cmd.ras_n;
  assign sd_cas_n_o = cmd.cas_n;
  assign sd_we_n_o  = cmd.we_n;

  p_idle_desel_r1: assert property (@(posedge clk) disable iff (!rst_s_q)
    rdy_o |-> sd_cs_n_o);
  p_accept_act_r1: assert property (@(posedge clk) disable iff (!rst_s_q)
    (rdy_o && req_i) |=> (!sd_cs_n_o && !sd_ras_n_o && sd_cas_n_o));
  p_ack_busy_r8: assert property (@(posedge clk) disable iff (!rst_s_q)
    ack_o |-> (!rdy_o && sd_ras_n_o && sd_cas_n_o));
endmodule

// File: tb/sdram_burst_rd_seq_tb.sv
module sdram_burst_rd_seq_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_i;
  logic [19:0]  addr_i;
  logic [1:0]   rcd_code_i, cl_code_i;
  logic [2:0]   tpc_code_i;
  logic         rdy_o, ack_o;
  logic [255:0] rd_data_o;
  logic         sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o;
  logic [0:0]   sd_ba_o;
  logic [10:0]  sd_a_o;
  logic [63:0]  sd_dq_i;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  sdram_burst_rd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .addr_i(addr_i),
    .rcd_code_i(rcd_code_i), .cl_code_i(cl_code_i), .tpc_code_i(tpc_code_i),
    .rdy_o(rdy_o), .ack_o(ack_o), .rd_data_o(rd_data_o),
    .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o), .sd_cas_n_o(sd_cas_n_o),
    .sd_we_n_o(sd_we_n_o), .sd_ba_o(sd_ba_o), .sd_a_o(sd_a_o), .sd_dq_i(sd_dq_i)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int t, input int b);
    return {32'(t), 16'hBEA7, 16'(b)};
  endfunction

  task automatic run_txn(input int t, input int rcd, input int cl, input int tpc,
                         input logic [19:0] adr, input bit hold);
    int rcdn = (rcd == 3) ? 4 : rcd + 2;
    int lat  = (cl == 0) ? 1 : cl;
    int rdc  = 1 + rcdn;
    int d1   = rdc + lat;
    int ackc = d1 + 4;
    int idlc = ackc + tpc + 1;
    bit ok_act = 1, ok_gap = 1, ok_rd = 1, ok_rda = 1, ok_clw = 1;
    bit ok_ack = 1, ok_rdy = 1, ok_tpc = 1, ok_dat = 1, ok_b0 = 1;
    logic [63:0] a_act = 0, a_gap = 0, a_rd = 0, a_rda = 0, a_clw = 0;
    logic [63:0] a_ack = 0, a_rdy = 0, a_tpc = 0;
    logic [3:0]  cmd;
    logic [10:0] col_exp;
    logic [255:0] dexp;
    col_exp = {1'b1, 2'b00, adr[7:0]};
    for (int b = 0; b < 4; b++) dexp[64*b +: 64] = pat(t, b);
    rcd_code_i = 2'(rcd); cl_code_i = 2'(cl); tpc_code_i = 3'(tpc);
    addr_i = adr;
    req_i = 1'b1;
    @(posedge clk);
    for (int k = 1; k <= idlc; k++) begin
      @(negedge clk);
      if (!hold || k == idlc) req_i = 1'b0;
      if (hold) addr_i = ~adr;
      sd_dq_i = (k >= d1 && k < d1 + 4) ? pat(t, k - d1) : 64'hDEAD_0000_0000_0000 | 64'(k);
      cmd = {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o};
      if (k == 1) begin
        if (cmd != 4'b0011 || sd_ba_o != adr[19] || sd_a_o != adr[18:8]) begin
          ok_act = 0; a_act = {cmd, sd_ba_o, sd_a_o};
        end
      end else if (k < rdc) begin
        if (cmd != 4'b0111) begin ok_gap = 0; a_gap = 64'(cmd); end
      end else if (k == rdc) begin
        if (cmd != 4'b0101) begin ok_rd = 0; a_rd = 64'(cmd); end
        if (sd_ba_o != adr[19] || sd_a_o != col_exp) begin
          ok_rda = 0; a_rda = {sd_ba_o, sd_a_o};
        end
      end else if (k < d1) begin
        if (cmd != 4'b0111) begin ok_clw = 0; a_clw = 64'(cmd); end
      end else if (k < idlc) begin
        if (cmd != 4'b0111) begin ok_tpc = 0; a_tpc = 64'(cmd); end
      end else begin
        if (cmd != 4'b1111) begin ok_tpc = 0; a_tpc = 64'(cmd); end
      end
      if (ack_o != (k == ackc)) begin ok_ack = 0; a_ack = 64'(k); end
      if (rdy_o != (k == idlc)) begin ok_rdy = 0; a_rdy = 64'(k); end
      if (k == ackc) begin
        if (rd_data_o != dexp) ok_dat = 0;
        if (rd_data_o[63:0] != pat(t, 0)) ok_b0 = 0;
      end
    end
    chk(ok_act, "R1 activate bank/row", a_act, {4'b0011, adr[19], adr[18:8]});
    chk(ok_rd,  "R2 read cycle placement", a_rd, 64'b0101);
    chk(ok_gap, "R3 NOP between activate and read", a_gap, 64'b0111);
    chk(ok_rda, "R4 read address with auto-precharge", a_rda, {adr[19], col_exp});
    chk(ok_clw && ok_b0, "R5 CAS latency first beat", {a_clw[31:0], rd_data_o[31:0]},
        {32'h7, pat(t, 0)[31:0]});
    chk(ok_dat, "R6 beat order", rd_data_o[255:192], dexp[255:192]);
    chk(ok_ack, "R7 completion pulse cycle", a_ack, 64'(ackc));
    chk(ok_rdy && ok_tpc, "R8 recovery length", a_rdy | a_tpc, 64'(idlc));
    if (hold) chk(ok_act && ok_rd && ok_tpc && ok_rdy, "R9 request held while busy",
                  a_tpc, 64'b0111);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int t;
    rst_n = 1'b0; req_i = 1'b0; addr_i = '0;
    rcd_code_i = '0; cl_code_i = '0; tpc_code_i = '0; sd_dq_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset/idle state
    chk(rdy_o == 1'b1, "R1 reset rdy", 64'(rdy_o), 64'd1);
    chk(ack_o == 1'b0, "R7 reset ack", 64'(ack_o), 64'd0);
    chk({sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o} == 4'b1111, "R1 idle deselect",
        64'({sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o}), 64'hF);
    t = 0;
    for (int rcd = 0; rcd < 4; rcd++)
      for (int cl = 0; cl < 4; cl++)
        for (int tpc = 0; tpc < 8; tpc++) begin
          run_txn(t, rcd, cl, tpc,
                  {1'(t), 11'(t * 37 + 5), 8'(t * 13 + 1)}, tpc[0]);
          t++;
        end
    @(negedge clk);
    chk(rdy_o == 1'b1, "R1 idle after sweep", 64'(rdy_o), 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule